// File: doc/BRIEF.md
# Single-Cycle MIPS Subset Processor

This block is a single-cycle processor for a small slice of the MIPS32 integer instruction set: `lw`, `sw`, `add`, `sub`, `and`, `or`, `slt`, `beq`, `j` and `jr`. Each rising clock edge retires one whole instruction. Fetch, decode, register read, ALU work, data memory access and register write-back all settle within that cycle. Instruction and data memories are word arrays inside the core.

While the core is held in reset, the surrounding logic fills the memories through a plain load port. The load port has no handshake: a write is accepted in the same cycle it is strobed, so it never applies back-pressure and never needs a ready signal. A debug port reads any register or data word combinationally, so results can be inspected without a memory-mapped path.

Two test pins model manufacturing defects in the control unit. One holds the destination-select line at 1, so the destination is always the `rd` field. The other holds the write-back-select line at 0, so the ALU result is always written back instead of load data. With these pins a tester can reproduce and diagnose a faulty part's behaviour.

Top module: `mips_sc_core`

## Requirements
- R1: While `rst` is high the PC reads 0 and every register reads 0. After `rst` falls, the first rising edge executes the word at byte address 0.
- R2: `add`, `sub`, `and`, `or` and `slt` (opcode 0, funct 0x20, 0x22, 0x24, 0x25, 0x2A) write rs op rt into register rd. `slt` is a signed compare that yields 1 or 0. The PC then advances by 4.
- R3: `lw` (opcode 0x23) loads the word at rs + sign-extended imm16 into rt. `sw` (opcode 0x2B) stores rt there. The word index is the byte address bits above bit 1.
- R4: `beq` (opcode 0x04) sets the PC to PC+4 + (sign-extended imm16 << 2) when rs equals rt, and to PC+4 otherwise.
- R5: `j` (opcode 0x02) sets the PC to {PC+4[31:28], index26, 2'b00}.
- R6: `jr` (opcode 0, funct 0x08) sets the PC to the value of register rs. It writes no register and no data memory word.
- R7: Register 0 always reads zero, and writes to it are discarded.
- R8: With `flt_dst_hi` set, an `lw` writes register bits 15:11 of the instruction instead of rt. For word 0x8D799C00 (base r11, rt r25, offset 0x9C00) that is register 19.
- R9: With `flt_wb_lo` set, an `lw` writes the computed address instead of the loaded data.
- R10: With both fault pins set, word 0x8D799C00 puts the address r11 + 0xFFFF9C00 into r19 and leaves r25 unchanged.
- R11: The load port writes instruction memory (`ld_dmem`=0) or data memory (`ld_dmem`=1) only while `rst` is high. It has no effect otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset; holds the core and enables loading |
| flt_dst_hi | input | 1 | Forces destination-select to rd |
| flt_wb_lo | input | 1 | Forces write-back-select to the ALU result |
| ld_we | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load target: 0 instruction, 1 data memory |
| ld_addr | input | 6 | Load word index |
| ld_data | input | 32 | Load word |
| dbg_reg_sel | input | 5 | Debug register number |
| dbg_reg_val | output | 32 | Debug register value |
| dbg_mem_sel | input | 6 | Debug data-memory word index |
| dbg_mem_val | output | 32 | Debug data-memory word |
| pc_out | output | 32 | Current program counter |

## Verification
The hardest situation to reach is a faulted load acting on meaningful state. Under a forced destination or write-back line, the ordinary set-up loads misdirect their own results, so faults cannot simply be held for the whole program. The bench therefore runs the program fault-free until `pc_out` reaches the faulty word, raises the fault pins for exactly that one edge, and lowers them again. It then checks r19 and r25 for each of the three fault combinations. A separate run checks that a `jr` target taken from a register skips the word after the jump.

// File: rtl/mips_sc_pkg.sv
package mips_sc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_JR  = 6'h08;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    NXT_SEQ,
    NXT_BRANCH,
    NXT_JUMP,
    NXT_REG
  } next_pc_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    wb_is_mem;
    logic    rf_write;
    logic    mem_write;
    logic    is_branch;
    logic    is_jump;
    logic    is_jreg;
    alu_fn_e alu_fn;
  } ctrl_t;
endpackage

// File: rtl/mips_sc_ctrl.sv
module mips_sc_ctrl
  import mips_sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{default: '0, alu_fn: ALU_ADD};
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.rf_write  = 1'b1;
        unique case (funct)
          FN_ADD: ctrl.alu_fn = ALU_ADD;
          FN_SUB: ctrl.alu_fn = ALU_SUB;
          FN_AND: ctrl.alu_fn = ALU_AND;
          FN_OR:  ctrl.alu_fn = ALU_OR;
          FN_SLT: ctrl.alu_fn = ALU_SLT;
          FN_JR: begin
            ctrl.rf_write = 1'b0;
            ctrl.is_jreg  = 1'b1;
          end
          default: ctrl.rf_write = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl.b_is_imm  = 1'b1;
        ctrl.wb_is_mem = 1'b1;
        ctrl.rf_write  = 1'b1;
      end
      OP_STORE: begin
        ctrl.b_is_imm  = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_fn    = ALU_SUB;
      end
      OP_JUMP: ctrl.is_jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/mips_sc_regfile.sv
module mips_sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd3
);
  logic [W-1:0]    regs [NREG];
  logic [NREG-1:0] sel;

  always_comb begin
    sel = '0;
    sel[wa] = we;
  end

  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)         regs[g] <= '0;
      else if (sel[g]) regs[g] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
  assign rd3 = regs[ra3];
endmodule

// File: rtl/mips_sc_alu.sv
module mips_sc_alu
  import mips_sc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] diff;
  assign diff = a - b;

  always_comb begin
    unique case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (diff == '0);
endmodule

// File: rtl/mips_sc_core.sv
module mips_sc_core
  import mips_sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flt_dst_hi,
  input  logic            flt_wb_lo,
  input  logic            ld_we,
  input  logic            ld_dmem,
  input  logic [LAW-1:0]  ld_addr,
  input  logic [31:0]     ld_data,
  input  logic [4:0]      dbg_reg_sel,
  output logic [31:0]     dbg_reg_val,
  input  logic [DAW-1:0]  dbg_mem_sel,
  output logic [31:0]     dbg_mem_val,
  output logic [31:0]     pc_out
);
  logic [XLEN-1:0] pc, pc_plus4, pc_next, br_target, j_target;
  logic [XLEN-1:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_res, rd_word, wb_data;
  logic [RAW-1:0]  wr_addr;
  logic            alu_zero, rf_we, dm_we, dst_sel, wb_sel;
  ctrl_t           ctrl;
  next_pc_e        nxt;

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  // fetch
  assign instr    = imem[pc[IAW+1:2]];
  assign pc_plus4 = pc + 32'd4;

  mips_sc_ctrl u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  // fault injection on the two control lines
  assign dst_sel = flt_dst_hi | ctrl.dst_is_rd;
  assign wb_sel  = ~flt_wb_lo & ctrl.wb_is_mem;

  assign wr_addr = dst_sel ? instr[15:11] : instr[20:16];
  assign rf_we   = ctrl.rf_write & ~rst;
  assign dm_we   = ctrl.mem_write & ~rst;

  mips_sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (rf_we),
    .wa  (wr_addr),
    .wd  (wb_data),
    .ra1 (instr[25:21]),
    .rd1 (rs_val),
    .ra2 (instr[20:16]),
    .rd2 (rt_val),
    .ra3 (dbg_reg_sel),
    .rd3 (dbg_reg_val)
  );

  assign imm_ext = {{16{instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.b_is_imm ? imm_ext : rt_val;

  mips_sc_alu #(.W(XLEN)) u_alu (
    .fn   (ctrl.alu_fn),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_res),
    .zero (alu_zero)
  );

  // data memory and load port
  assign rd_word     = dmem[alu_res[DAW+1:2]];
  assign dbg_mem_val = dmem[dbg_mem_sel];
  assign wb_data     = wb_sel ? rd_word : alu_res;

  always_ff @(posedge clk) begin
    if (rst && ld_we && ld_dmem)
      dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (dm_we)
      dmem[alu_res[DAW+1:2]] <= rt_val;
  end

  always_ff @(posedge clk) begin
    if (rst && ld_we && !ld_dmem)
      imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  // next PC
  assign br_target = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.is_jreg)                    nxt = NXT_REG;
    else if (ctrl.is_jump)               nxt = NXT_JUMP;
    else if (ctrl.is_branch && alu_zero) nxt = NXT_BRANCH;
    else                                 nxt = NXT_SEQ;
  end

  always_comb begin
    unique case (nxt)
      NXT_REG:    pc_next = rs_val;
      NXT_JUMP:   pc_next = j_target;
      NXT_BRANCH: pc_next = br_target;
      default:    pc_next = pc_plus4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign pc_out = pc;
endmodule

// File: rtl/mips_sc_checker.sv
module mips_sc_checker (
  input logic        clk,
  input logic        rst,
  input logic        flt_dst_hi,
  input logic        flt_wb_lo,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        rf_we,
  input logic [4:0]  rf_wa,
  input logic [31:0] rf_wd,
  input logic [31:0] alu_res,
  input logic        dm_we
);
  logic        is_r, is_jr, is_lw, is_sw, is_beq, is_j, is_alu;
  logic [31:0] seq_pc, jmp_pc, br_pc;

  assign is_r   = instr[31:26] == 6'h00;
  assign is_jr  = is_r && instr[5:0] == 6'h08;
  assign is_alu = is_r && (instr[5:0] == 6'h20 || instr[5:0] == 6'h22 ||
                  instr[5:0] == 6'h24 || instr[5:0] == 6'h25 || instr[5:0] == 6'h2A);
  assign is_lw  = instr[31:26] == 6'h23;
  assign is_sw  = instr[31:26] == 6'h2B;
  assign is_beq = instr[31:26] == 6'h04;
  assign is_j   = instr[31:26] == 6'h02;
  assign seq_pc = pc + 32'd4;
  assign jmp_pc = {seq_pc[31:28], instr[25:0], 2'b00};
  assign br_pc  = seq_pc + {{14{instr[15]}}, instr[15:0], 2'b00};

  a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
    (is_alu || is_lw || is_sw) |=> pc == $past(seq_pc));

  a_r4_beq_taken: assert property (@(posedge clk) disable iff (rst)
    (is_beq && rs_val == rt_val) |=> pc == $past(br_pc));

  a_r4_beq_fall: assert property (@(posedge clk) disable iff (rst)
    (is_beq && rs_val != rt_val) |=> pc == $past(seq_pc));

  a_r5_jump: assert property (@(posedge clk) disable iff (rst)
    is_j |=> pc == $past(jmp_pc));

  a_r6_jr_target: assert property (@(posedge clk) disable iff (rst)
    is_jr |=> pc == $past(rs_val));

  a_r6_jr_quiet: assert property (@(posedge clk) disable iff (rst)
    is_jr |-> !rf_we && !dm_we);

  a_r7_zero_read: assert property (@(posedge clk) disable iff (rst)
    instr[25:21] == 5'd0 |-> rs_val == 32'd0);

  a_r8_dst_fault: assert property (@(posedge clk) disable iff (rst)
    (flt_dst_hi && is_lw) |-> rf_wa == instr[15:11]);

  a_r9_wb_fault: assert property (@(posedge clk) disable iff (rst)
    (flt_wb_lo && is_lw) |-> rf_wd == alu_res);
endmodule

bind mips_sc_core mips_sc_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .flt_dst_hi (flt_dst_hi),
  .flt_wb_lo  (flt_wb_lo),
  .pc         (pc),
  .instr      (instr),
  .rs_val     (rs_val),
  .rt_val     (rt_val),
  .rf_we      (rf_we),
  .rf_wa      (wr_addr),
  .rf_wd      (wb_data),
  .alu_res    (alu_res),
  .dm_we      (dm_we)
);

// File: tb/test_mips_sc_core.sv
`timescale 1ns/1ps
module test_mips_sc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flt_dst_hi = 1'b0, flt_wb_lo = 1'b0;
  logic        ld_we = 1'b0, ld_dmem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  dbg_reg_sel = '0;
  logic [31:0] dbg_reg_val, dbg_mem_val, pc_out;
  logic [5:0]  dbg_mem_sel = '0;
  int          n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  mips_sc_core i_mips_sc_core (
    .clk(clk), .rst(rst), .flt_dst_hi(flt_dst_hi), .flt_wb_lo(flt_wb_lo),
    .ld_we(ld_we), .ld_dmem(ld_dmem), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
    .dbg_mem_sel(dbg_mem_sel), .dbg_mem_val(dbg_mem_val), .pc_out(pc_out)
  );

  function automatic logic [31:0] rt_i(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] it_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic peek_reg(input int r, input string tag, input logic [31:0] exp);
    @(negedge clk);
    dbg_reg_sel = r[4:0];
    #1 check(tag, dbg_reg_val, exp);
  endtask

  task automatic peek_mem(input int w, input string tag, input logic [31:0] exp);
    @(negedge clk);
    dbg_mem_sel = w[5:0];
    #1 check(tag, dbg_mem_val, exp);
  endtask

  task automatic put(input logic dm, input int a, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_dmem = dm; ld_addr = a[5:0]; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // reset, then load program and data
  task automatic load_all();
    logic [31:0] p [22];
    @(negedge clk);
    rst = 1'b1; flt_dst_hi = 1'b0; flt_wb_lo = 1'b0;
    p[0]  = it_i(6'h23, 0, 1, 16'd0);
    p[1]  = it_i(6'h23, 0, 2, 16'd4);
    p[2]  = it_i(6'h23, 0, 11, 16'd8);
    p[3]  = it_i(6'h23, 0, 3, 16'd12);
    p[4]  = rt_i(1, 2, 4, 6'h20);
    p[5]  = rt_i(1, 2, 5, 6'h22);
    p[6]  = rt_i(1, 2, 6, 6'h24);
    p[7]  = rt_i(1, 2, 7, 6'h25);
    p[8]  = rt_i(2, 1, 8, 6'h2A);
    p[9]  = rt_i(1, 2, 13, 6'h2A);
    p[10] = rt_i(1, 2, 0, 6'h20);
    p[11] = it_i(6'h2B, 0, 4, 16'd20);
    p[12] = it_i(6'h04, 1, 1, 16'd1);
    p[13] = rt_i(1, 1, 9, 6'h20);
    p[14] = it_i(6'h04, 1, 2, 16'd4);
    p[15] = rt_i(3, 0, 0, 6'h08);
    p[16] = rt_i(1, 1, 10, 6'h20);
    p[17] = 32'h8D79_9C00;
    p[18] = {6'h02, 26'h15};
    p[19] = rt_i(1, 1, 12, 6'h20);
    p[20] = rt_i(1, 1, 12, 6'h20);
    p[21] = it_i(6'h04, 0, 0, 16'hFFFF);
    for (int i = 0; i < 22; i++) put(1'b0, i, p[i]);
    put(1'b1, 0, 32'd7);
    put(1'b1, 1, 32'd5);
    put(1'b1, 2, 32'h0000_6410);
    put(1'b1, 3, 32'h0000_0044);
    put(1'b1, 4, 32'hCAFE_F00D);
    put(1'b1, 5, 32'd0);
    put(1'b1, 6, 32'h0000_1234);
  endtask

  task automatic run(input int n);
    @(negedge clk);
    rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    load_all();
    #1 check("R1 pc in reset", pc_out, 32'd0);
    peek_reg(4, "R1 reg clear in reset", 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1 check("R1 first edge executes word 0", pc_out, 32'd4);
    peek_reg(1, "R1 word 0 loaded r1", 32'd7);
  endtask

  task automatic t_program();
    load_all();
    run(40);
    peek_reg(4, "R2 add", 32'd12);
    peek_reg(5, "R2 sub", 32'd2);
    peek_reg(6, "R2 and", 32'd5);
    peek_reg(7, "R2 or", 32'd7);
    peek_reg(8, "R2 slt true", 32'd1);
    peek_reg(13, "R2 slt false", 32'd0);
    peek_reg(2, "R3 lw", 32'd5);
    peek_reg(25, "R3 lw negative offset", 32'hCAFE_F00D);
    peek_mem(5, "R3 sw", 32'd12);
    peek_reg(9, "R4 beq taken skips", 32'd0);
    peek_reg(12, "R5 j skips", 32'd0);
    #1 check("R5 j reaches halt loop", pc_out, 32'h54);
    peek_reg(10, "R6 jr skips next", 32'd0);
    peek_reg(3, "R6 jr source kept", 32'h44);
    peek_reg(0, "R7 r0 reads zero", 32'd0);
    peek_reg(19, "R8 no fault r19 untouched", 32'd0);
    // R11: load port while running has no effect
    put(1'b1, 6, 32'hDEAD_BEEF);
    peek_mem(6, "R11 load ignored out of reset", 32'h0000_1234);
  endtask

  task automatic t_fault(input logic fd, input logic fw, input string tag,
                         input logic [31:0] e19, input logic [31:0] e25);
    int guard;
    load_all();
    @(negedge clk);
    rst = 1'b0;
    guard = 0;
    while (pc_out != 32'h44 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    flt_dst_hi = fd; flt_wb_lo = fw;
    @(negedge clk);
    flt_dst_hi = 1'b0; flt_wb_lo = 1'b0;
    repeat (10) @(negedge clk);
    peek_reg(19, {tag, " r19"}, e19);
    peek_reg(25, {tag, " r25"}, e25);
    #1 check({tag, " pc continues"}, pc_out, 32'h54);
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_program();
    t_fault(1'b1, 1'b0, "R8 dst fault", 32'hCAFE_F00D, 32'd0);
    t_fault(1'b0, 1'b1, "R9 wb fault", 32'd0, 32'h0000_0010);
    t_fault(1'b1, 1'b1, "R10 both faults", 32'h0000_0010, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule